// File: doc/BRIEF.md
# Pending Interrupt ID Resolver

This block sits behind a three-bank interrupt controller. It watches the three pending words and names the one interrupt that service code should handle next. Bank 0 is a mixed word. It holds eight sources of its own, two summary flags that stand for whole secondary banks, and a run of shortcut flags. Each shortcut flag mirrors one chosen source that really lives in bank 1 or bank 2.

The resolver masks bank 0 to its meaningful bits and picks a winning group in a fixed order. It takes the lowest set bit inside that group and turns the result into a 7-bit hardware ID. A shortcut flag is traced back to the source it stands for. A summary flag sends the search into the pending word of its bank.

The result is registered, so it appears one clock after the inputs are sampled. Acknowledging and clearing sources is left to the caller. The caller presents fresh pending words after each service and reads the next ID.

Top module: `pend_id_resolver`

## Requirements
- R1: The ID is 7 bits wide. Bits [6:5] hold the bank number and bits [4:0] hold the source index inside that bank. Bank code 3 never appears on a valid ID.
- R2: Bits 21 to 31 of the bank 0 word play no part in the result.
- R3: Any set bank 0 bit in positions 0 to 7 takes priority over every other group. The lowest such bit is reported with bank code 0.
- R4: When bits 0 to 7 are clear and any of bits 10 to 14 is set, the lowest of these wins. Bits 10, 11, 12, 13 and 14 report bank 1 sources 7, 9, 10, 18 and 19.
- R5: When bits 0 to 7 and 10 to 14 are clear and any of bits 15 to 20 is set, the lowest of these wins. Bits 15 through 20 report bank 2 sources 21, 22, 23, 24, 25 and 30.
- R6: The bank 1 summary flag (bank 0 bit 8) ranks next. It reports bank 1 together with the lowest set bit of the bank 1 word. The bank 1 word is not consulted unless this flag is the winning group.
- R7: The bank 2 summary flag (bank 0 bit 9) ranks last. It reports bank 2 together with the lowest set bit of the bank 2 word.
- R8: When none of bank 0 bits 0 to 20 is set, the ID is the all-ones value 127. The valid output is low exactly when the ID equals 127.
- R9: A winning summary flag whose bank word is zero yields the value 127 with valid low. This holds even when a lower-priority summary flag is also set.
- R10: The ID and valid outputs are registered, with one clock of latency. While reset is held they read 127 and low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bank0Pend | input | 32 | Bank 0 pending word: own sources, summaries, shortcuts |
| bank1Pend | input | 32 | Bank 1 pending word |
| bank2Pend | input | 32 | Bank 2 pending word |
| nextId | output | 7 | Registered ID of the next interrupt, 127 when none |
| nextValid | output | 1 | High when nextId names a real interrupt |

## Verification
The hardest cases come from contradictions between the words. A summary flag can be set while its bank word is empty. A bank word can carry bits while its summary flag is clear. A lower group can be dense while a single higher-group bit sits at the far end of its range. Uniform random words almost never reach these cases. The stimulus therefore builds bank 0 by ANDing several random draws so that bits are sparse, and zeroes the secondary words at random. Directed vectors then walk each shortcut bit alone and each empty-summary combination.

// File: rtl/pend_id_pkg.sv
package pend_id_pkg;

  localparam int WORD_W   = 32;
  localparam int IDX_W    = 5;
  localparam int BANK_W   = 2;
  localparam int ID_W     = BANK_W + IDX_W;
  localparam int NATIVE_N = 8;
  localparam int SUM1_POS = 8;
  localparam int SUM2_POS = 9;
  localparam int SC1_LO   = 10;
  localparam int SC1_N    = 5;
  localparam int SC2_LO   = SC1_LO + SC1_N;
  localparam int SC2_N    = 6;
  localparam int VALID_W  = SC2_LO + SC2_N;
  localparam int GRP_N    = 5;

  localparam logic [WORD_W-1:0] VALID_MASK = WORD_W'((64'd1 << VALID_W) - 64'd1);
  localparam logic [ID_W-1:0]   ID_NONE    = '1;

  // group ranking: native, shortcut bank1, shortcut bank2, summary1, summary2
  localparam int GRP_LSB [GRP_N] = '{0, SC1_LO, SC2_LO, SUM1_POS, SUM2_POS};
  localparam int GRP_CNT [GRP_N] = '{NATIVE_N, SC1_N, SC2_N, 1, 1};

  typedef struct packed {
    logic selNative;
    logic selSc1;
    logic selSc2;
    logic selSum1;
    logic selSum2;
  } grpSel_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } scan_t;

  function automatic scan_t findLowest(logic [WORD_W-1:0] w);
    scan_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (w[i]) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(i);
      end
    end
    return r;
  endfunction

  // shortcut slot -> real source index in its home bank
  function automatic logic [IDX_W-1:0] scSource(int unsigned slot);
    logic [IDX_W-1:0] s;
    case (slot)
      0:       s = IDX_W'(7);
      1:       s = IDX_W'(9);
      2:       s = IDX_W'(10);
      3:       s = IDX_W'(18);
      4:       s = IDX_W'(19);
      5:       s = IDX_W'(21);
      6:       s = IDX_W'(22);
      7:       s = IDX_W'(23);
      8:       s = IDX_W'(24);
      9:       s = IDX_W'(25);
      10:      s = IDX_W'(30);
      default: s = '1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pend_id_ctrl.sv
module pend_id_ctrl
  import pend_id_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] bank0Pend,
  output grpSel_t           sel
);

  logic [WORD_W-1:0] bank0Masked;
  logic [GRP_N-1:0]  grpAny;
  logic [GRP_N-1:0]  grpWin;

  assign bank0Masked = bank0Pend & VALID_MASK;

  for (genvar g = 0; g < GRP_N; g++) begin : gGroup
    localparam logic [WORD_W-1:0] GMASK =
      WORD_W'(((64'd1 << GRP_CNT[g]) - 64'd1) << GRP_LSB[g]);
    assign grpAny[g] = |(bank0Masked & GMASK);
  end

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int g = 0; g < GRP_N; g++) begin
      grpWin[g] = grpAny[g] && !blocked;
      blocked   = blocked | grpAny[g];
    end
  end

  assign sel.selNative = grpWin[0];
  assign sel.selSc1    = grpWin[1];
  assign sel.selSc2    = grpWin[2];
  assign sel.selSum1   = grpWin[3];
  assign sel.selSum2   = grpWin[4];

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel)); // R3
  AST_NATIVE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (|bank0Pend[NATIVE_N-1:0]) |-> sel.selNative); // R3
  AST_SUM2_LAST: assert property (@(posedge clk) disable iff (!rstN)
    sel.selSum2 |-> !bank0Pend[SUM1_POS]); // R7

endmodule

// File: rtl/pend_id_dpath.sv
module pend_id_dpath
  import pend_id_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  grpSel_t           sel,
  input  logic [WORD_W-1:0] bank0Pend,
  input  logic [WORD_W-1:0] bank1Pend,
  input  logic [WORD_W-1:0] bank2Pend,
  output logic [ID_W-1:0]   nextId,
  output logic              nextValid
);

  scan_t natScan, sc1Scan, sc2Scan, b1Scan, b2Scan;
  logic [ID_W-1:0] idD;
  logic            validD;

  assign natScan = findLowest(WORD_W'(bank0Pend[NATIVE_N-1:0]));
  assign sc1Scan = findLowest(WORD_W'(bank0Pend[SC1_LO +: SC1_N]));
  assign sc2Scan = findLowest(WORD_W'(bank0Pend[SC2_LO +: SC2_N]));
  assign b1Scan  = findLowest(bank1Pend);
  assign b2Scan  = findLowest(bank2Pend);

  always_comb begin
    idD    = ID_NONE;
    validD = 1'b0;
    if (sel.selNative) begin
      idD    = {BANK_W'(0), natScan.idx};
      validD = 1'b1;
    end else if (sel.selSc1) begin
      idD    = {BANK_W'(1), scSource(int'(sc1Scan.idx))};
      validD = 1'b1;
    end else if (sel.selSc2) begin
      idD    = {BANK_W'(2), scSource(int'(sc2Scan.idx) + SC1_N)};
      validD = 1'b1;
    end else if (sel.selSum1) begin
      if (b1Scan.hit) begin
        idD    = {BANK_W'(1), b1Scan.idx};
        validD = 1'b1;
      end
    end else if (sel.selSum2) begin
      if (b2Scan.hit) begin
        idD    = {BANK_W'(2), b2Scan.idx};
        validD = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextId    <= ID_NONE;
      nextValid <= 1'b0;
    end else begin
      nextId    <= idD;
      nextValid <= validD;
    end
  end

  AST_VALID_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    nextValid == (nextId != ID_NONE)); // R8
  AST_EMPTY_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    ((bank0Pend & VALID_MASK) == '0) |=> !nextValid); // R8
  AST_EMPTY_SUM1: assert property (@(posedge clk) disable iff (!rstN)
    (sel.selSum1 && bank1Pend == '0) |=> !nextValid); // R9
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    nextValid |-> nextId[ID_W-1 -: BANK_W] != BANK_W'(3)); // R1
  AST_NATIVE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (nextValid && nextId[ID_W-1 -: BANK_W] == '0) |-> nextId[IDX_W-1:0] < IDX_W'(NATIVE_N)); // R3

endmodule

// File: rtl/pend_id_resolver.sv
module pend_id_resolver
  import pend_id_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] bank0Pend,
  input  logic [WORD_W-1:0] bank1Pend,
  input  logic [WORD_W-1:0] bank2Pend,
  output logic [ID_W-1:0]   nextId,
  output logic              nextValid
);

  grpSel_t sel;

  pend_id_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bank0Pend (bank0Pend),
    .sel       (sel)
  );

  pend_id_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .sel       (sel),
    .bank0Pend (bank0Pend),
    .bank1Pend (bank1Pend),
    .bank2Pend (bank2Pend),
    .nextId    (nextId),
    .nextValid (nextValid)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rstN) |-> (nextId == ID_NONE && !nextValid)); // R10

endmodule

// File: tb/pend_id_resolver_bench.sv
module pend_id_resolver_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] b0 = '0, b1 = '0, b2 = '0;
  logic [6:0]  nextId;
  logic        nextValid;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  pend_id_resolver u_pend_id_resolver (
    .clk(clk), .rstN(rstN), .bank0Pend(b0), .bank1Pend(b1), .bank2Pend(b2),
    .nextId(nextId), .nextValid(nextValid)
  );

  function automatic int lowBit(logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return -1;
  endfunction

  // returns {valid, id}; tag names the governing requirement
  function automatic logic [7:0] model(logic [31:0] a, logic [31:0] p1,
                                       logic [31:0] p2, output string tag);
    int sc [11] = '{7, 9, 10, 18, 19, 21, 22, 23, 24, 25, 30};
    int k;
    if (a[20:0] == '0) begin tag = "R8"; return {1'b0, 7'h7f}; end
    if (a[7:0] != '0) begin
      tag = "R3"; return {1'b1, 2'd0, 5'(lowBit({24'd0, a[7:0]}))};
    end
    if (a[14:10] != '0) begin
      k = lowBit({27'd0, a[14:10]});
      tag = "R4"; return {1'b1, 2'd1, 5'(sc[k])};
    end
    if (a[20:15] != '0) begin
      k = lowBit({26'd0, a[20:15]});
      tag = "R5"; return {1'b1, 2'd2, 5'(sc[5 + k])};
    end
    if (a[8]) begin
      if (p1 == '0) begin tag = "R9"; return {1'b0, 7'h7f}; end
      tag = "R6"; return {1'b1, 2'd1, 5'(lowBit(p1))};
    end
    if (p2 == '0) begin tag = "R9"; return {1'b0, 7'h7f}; end
    tag = "R7"; return {1'b1, 2'd2, 5'(lowBit(p2))};
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] p1, logic [31:0] p2, string why);
    string tag;
    logic [7:0] exp;
    @(negedge clk);
    b0 = a; b1 = p1; b2 = p2;
    exp = model(a, p1, p2, tag);
    @(negedge clk);
    checks++;
    if ({nextValid, nextId} !== exp) begin
      fails++;
      $display("FAIL %s %s (R10 latency, R1 encoding): actual valid=%0b id=%0d expected valid=%0b id=%0d",
               tag, why, nextValid, nextId, exp[7], exp[6:0]);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    b0 = 32'h0000_0001;
    repeat (3) @(negedge clk);
    checks++;
    if (nextId !== 7'h7f || nextValid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual valid=%0b id=%0d expected valid=0 id=127", nextValid, nextId);
    end
    rstN = 1'b1;

    apply(32'h0, 32'hffff_ffff, 32'hffff_ffff, "R8 empty");
    apply(32'hffe0_0000, 32'h1, 32'h1, "R2 high bits ignored");
    apply(32'hffe0_0080 | 32'h0010_0700, 32'h1, 32'h1, "R3 native over all");
    apply(32'h0000_0006, 32'h0, 32'h0, "R3 lowest native");
    for (int p = 10; p <= 20; p++) apply(32'h1 << p, 32'h1, 32'h1, "R4/R5 single shortcut");
    apply(32'h001f_8300 | 32'h0000_4000, 32'h1, 32'h1, "R4 over R5");
    apply(32'h0000_0300, 32'h0000_0800, 32'h4, "R6 summary1");
    apply(32'h0000_0200, 32'h0000_0800, 32'h0, "R6 bank1 ignored without flag, R9");
    apply(32'h0000_0300, 32'h0, 32'h8000_0000, "R9 empty summary1 with summary2");
    apply(32'h0000_0200, 32'h0, 32'h8000_0000, "R7 summary2 top bit");
    apply(32'h0000_0200, 32'hffff_ffff, 32'h0, "R9 empty summary2");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, p1, p2;
      a  = $urandom() & $urandom() & $urandom();
      if (n % 3 == 0) a = a & 32'hffff_fb00;
      if (n % 5 == 0) a = a & 32'hffe0_0300;
      p1 = ($urandom() % 4 == 0) ? 32'h0 : ($urandom() & $urandom());
      p2 = ($urandom() % 4 == 0) ? 32'h0 : ($urandom() & $urandom());
      apply(a, p1, p2, "random");
    end

    summary();
    $finish;
  end

endmodule